// File: doc/BRIEF.md
# Segment-Lookaside MMU Fault Classifier

This block takes the outcome of a 64-bit address translation attempt and decides, in a single pass, whether the access completes or faults. The surrounding pipeline gives it several things: the access kind and the two translation enables (one for instruction fetch, one for data). It also gives the effective address, the segment lookaside result (hit and no-execute), and the page table entry result (found, rights, real address and whether the changed bit is being set). The segment search, the hash and the page table entry fetch all happen outside the block.

One cycle after a request, the block presents exactly one of two results. The first is a TLB fill, carrying the page-aligned effective page, the page-aligned real page and the granted rights. The second is an exception, carrying its kind, an error code and, for data accesses, the fault address and the data-storage status word. The checks run in a fixed priority, so when several problems occur together the fault reported is always the earliest one.

Top module: `slb_fault_classifier`

## Requirements
- R1: While reset is asserted, and on the first idle cycles after it, `fill_valid` and `exc_valid` are both low.
- R2: Access kind encoding is 0 = load, 1 = store, 2 = fetch; kind 3 must never be presented. For each valid request, exactly one of `fill_valid` / `exc_valid` is high in the following cycle. Neither is high in a cycle that follows no request.
- R3: If the enable for the access kind is off (`xlat_fetch_en` for fetch, `xlat_data_en` for load/store), a fill is produced. Its real page is the effective address with bits 63..60 cleared and page-aligned, and its rights are 3'b111. The segment and page table entry inputs are ignored in this case.
- R4: A segment miss on a fetch gives exception kind 3 (instruction segment) with code 0, no DAR and no DSISR. On a load or store it gives kind 4 (data segment) with code 0, DAR equal to the effective address, and no DSISR.
- R5: A fetch from a segment with the no-execute bit set gives kind 1 (instruction storage) with code 0x10000000. For loads and stores the no-execute bit has no effect.
- R6: A page table entry miss on a fetch gives kind 1 with code 0x40000000. On a load it gives kind 2 (data storage) with code 0, DAR = effective address and DSISR 0x40000000. On a store it gives the same but with DSISR 0x42000000 (bit 25 marks a store).
- R7: Rights are bit 0 = read, bit 1 = write, bit 2 = execute; a load needs read, a store needs write and a fetch needs execute. If the needed right is missing, a fetch gives kind 1 with code 0x08000000. A load gives kind 2 with DSISR 0x08000000, and a store gives kind 2 with DSISR 0x0A000000; both data cases carry DAR = effective address and code 0.
- R8: The checks are applied in this order: translation off, segment miss, segment no-execute on fetch, page table entry miss, permission. Only the first failing check is reported.
- R9: On success, the fill's effective page and real page are the effective address and the entry's real address, each with the low 12 bits cleared. The rights are the entry's rights, with write cleared when the changed-bit update flag is low. The permission check of R7 uses the rights from before that clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| xlat_fetch_en | input | 1 | Translation enable for fetches |
| xlat_data_en | input | 1 | Translation enable for loads and stores |
| req_ea | input | 64 | Effective address |
| seg_hit | input | 1 | Segment lookaside buffer hit |
| seg_noexec | input | 1 | No-execute bit of the matched segment |
| pte_hit | input | 1 | Page table entry found |
| pte_rights | input | 3 | Entry rights: bit0 read, bit1 write, bit2 execute |
| pte_real | input | 64 | Real address given by the entry |
| pte_chg_set | input | 1 | Changed bit is being set by this access |
| fill_valid | output | 1 | TLB fill strobe |
| fill_ea_page | output | 64 | Page-aligned effective address |
| fill_ra_page | output | 64 | Page-aligned real address |
| fill_rights | output | 3 | Granted rights |
| exc_valid | output | 1 | Exception strobe |
| exc_kind | output | 3 | 1 instr storage, 2 data storage, 3 instr segment, 4 data segment |
| exc_code | output | 32 | Error code |
| exc_dar_wr | output | 1 | Fault address register is to be written |
| exc_dar | output | 64 | Fault address value |
| exc_dsisr_wr | output | 1 | Data-storage status word is to be written |
| exc_dsisr | output | 32 | Data-storage status word value |

## Verification
On every cycle, the assertions check a set of structural rules. The two strobes never rise together, every legal request is answered one cycle later, and no output appears without a request. Fill addresses are always page-aligned. Instruction-side exceptions never write DAR or DSISR, and a data-segment fault writes DAR but not DSISR. The numeric codes, the real-mode masking, the write-drop rule and the check priority under overlapping faults can only be shown by the scoreboard. It compares every result field against values computed from the requirements, for directed corner cases and for a long random mix.

// File: rtl/slb_fault_pkg.sv
package slb_fault_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_BAD   = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      EXC_NONE  = 3'd0,
      EXC_ISTOR = 3'd1,
      EXC_DSTOR = 3'd2,
      EXC_ISEG  = 3'd3,
      EXC_DSEG  = 3'd4
   } exc_kind_e;

   // outcome of the ordered check chain
   typedef enum logic [2:0] {
      V_NONE,
      V_REAL,
      V_SEG_MISS,
      V_NOEXEC,
      V_PTE_MISS,
      V_PROT,
      V_PTE_OK
   } verdict_e;

   localparam int RIGHTS_W = 3;
   localparam int RT_RD    = 0;
   localparam int RT_WR    = 1;
   localparam int RT_EX    = 2;

   localparam int CODE_W = 32;
   // status bit positions read by the exception handler
   localparam int BIT_NOTFOUND = 30;
   localparam int BIT_NOEXEC   = 28;
   localparam int BIT_PROT     = 27;
   localparam int BIT_STORE    = 25;

   localparam logic [CODE_W-1:0] CODE_NOTFOUND = CODE_W'(1) << BIT_NOTFOUND;
   localparam logic [CODE_W-1:0] CODE_NOEXEC   = CODE_W'(1) << BIT_NOEXEC;
   localparam logic [CODE_W-1:0] CODE_PROT     = CODE_W'(1) << BIT_PROT;
   localparam logic [CODE_W-1:0] CODE_STORE    = CODE_W'(1) << BIT_STORE;

endpackage

// File: rtl/sfc_real_gate.sv
module sfc_real_gate
   import slb_fault_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int HI_IGNORE = 4
) (
   input  logic [1:0]        kind,
   input  logic              fetch_en,
   input  logic              data_en,
   input  logic [ADDR_W-1:0] ea,
   output logic              real_mode,
   output logic [ADDR_W-1:0] real_addr
);
   localparam int LOW_KEEP = ADDR_W - HI_IGNORE;

   always_comb begin
      if (kind == ACC_FETCH) real_mode = !fetch_en;
      else                   real_mode = !data_en;
   end

   generate
      if (HI_IGNORE == 0) begin : g_nomask
         assign real_addr = ea;
      end else begin : g_mask
         assign real_addr = {{HI_IGNORE{1'b0}}, ea[LOW_KEEP-1:0]};
      end
   endgenerate

endmodule

// File: rtl/sfc_stage_chain.sv
module sfc_stage_chain
   import slb_fault_pkg::*;
(
   input  logic [1:0]          kind,
   input  logic                real_mode,
   input  logic                seg_hit,
   input  logic                seg_noexec,
   input  logic                pte_hit,
   input  logic [RIGHTS_W-1:0] pte_rights,
   input  logic                pte_chg_set,
   output verdict_e            verdict,
   output logic [RIGHTS_W-1:0] granted
);
   logic [RIGHTS_W-1:0] need;
   logic [RIGHTS_W-1:0] pte_eff;
   logic                missing;

   always_comb begin
      need = '0;
      case (kind)
         ACC_LOAD:  need[RT_RD] = 1'b1;
         ACC_STORE: need[RT_WR] = 1'b1;
         ACC_FETCH: need[RT_EX] = 1'b1;
         default:   need = '0;
      endcase
   end

   assign missing = |(need & ~pte_rights);

   always_comb begin
      pte_eff = pte_rights;
      if (!pte_chg_set) pte_eff[RT_WR] = 1'b0;
   end

   always_comb begin
      if (kind == ACC_BAD)                       verdict = V_NONE;
      else if (real_mode)                        verdict = V_REAL;
      else if (!seg_hit)                         verdict = V_SEG_MISS;
      else if (kind == ACC_FETCH && seg_noexec)  verdict = V_NOEXEC;
      else if (!pte_hit)                         verdict = V_PTE_MISS;
      else if (missing)                          verdict = V_PROT;
      else                                       verdict = V_PTE_OK;
   end

   assign granted = (verdict == V_REAL) ? {RIGHTS_W{1'b1}} : pte_eff;

endmodule

// File: rtl/sfc_exc_encode.sv
module sfc_exc_encode
   import slb_fault_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  verdict_e            verdict,
   input  logic [1:0]          kind,
   input  logic [ADDR_W-1:0]   ea,
   output logic                exc,
   output logic [2:0]          exc_kind,
   output logic [CODE_W-1:0]   code,
   output logic                dar_wr,
   output logic [ADDR_W-1:0]   dar,
   output logic                dsisr_wr,
   output logic [CODE_W-1:0]   dsisr
);
   logic is_fetch;
   logic [CODE_W-1:0] st_bit;

   assign is_fetch = (kind == ACC_FETCH);
   assign st_bit   = (kind == ACC_STORE) ? CODE_STORE : '0;

   always_comb begin
      exc      = 1'b0;
      exc_kind = EXC_NONE;
      code     = '0;
      dar_wr   = 1'b0;
      dsisr_wr = 1'b0;
      dsisr    = '0;
      case (verdict)
         V_SEG_MISS: begin
            exc = 1'b1;
            if (is_fetch) exc_kind = EXC_ISEG;
            else begin
               exc_kind = EXC_DSEG;
               dar_wr   = 1'b1;
            end
         end
         V_NOEXEC: begin
            exc      = 1'b1;
            exc_kind = EXC_ISTOR;
            code     = CODE_NOEXEC;
         end
         V_PTE_MISS, V_PROT: begin
            exc = 1'b1;
            if (is_fetch) begin
               exc_kind = EXC_ISTOR;
               code     = (verdict == V_PTE_MISS) ? CODE_NOTFOUND : CODE_PROT;
            end else begin
               exc_kind = EXC_DSTOR;
               dar_wr   = 1'b1;
               dsisr_wr = 1'b1;
               dsisr    = ((verdict == V_PTE_MISS) ? CODE_NOTFOUND : CODE_PROT) | st_bit;
            end
         end
         default: exc = 1'b0;
      endcase
   end

   assign dar = dar_wr ? ea : '0;

endmodule

// File: rtl/slb_fault_classifier.sv
module slb_fault_classifier
   import slb_fault_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int HI_IGNORE  = 4,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_kind,
   input  logic                xlat_fetch_en,
   input  logic                xlat_data_en,
   input  logic [ADDR_W-1:0]   req_ea,
   input  logic                seg_hit,
   input  logic                seg_noexec,
   input  logic                pte_hit,
   input  logic [2:0]          pte_rights,
   input  logic [ADDR_W-1:0]   pte_real,
   input  logic                pte_chg_set,
   output logic                fill_valid,
   output logic [ADDR_W-1:0]   fill_ea_page,
   output logic [ADDR_W-1:0]   fill_ra_page,
   output logic [2:0]          fill_rights,
   output logic                exc_valid,
   output logic [2:0]          exc_kind,
   output logic [31:0]         exc_code,
   output logic                exc_dar_wr,
   output logic [ADDR_W-1:0]   exc_dar,
   output logic                exc_dsisr_wr,
   output logic [31:0]         exc_dsisr
);
   localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));

   generate
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_bad_page
         $error("PAGE_SHIFT must lie inside the address width");
      end
      if (HI_IGNORE < 0 || HI_IGNORE >= ADDR_W - PAGE_SHIFT) begin : g_bad_hi
         $error("HI_IGNORE must leave the page number bits");
      end
   endgenerate

   logic                real_mode;
   logic [ADDR_W-1:0]   real_addr;
   verdict_e            verdict;
   logic [RIGHTS_W-1:0] granted;

   logic                n_exc;
   logic [2:0]          n_kind;
   logic [CODE_W-1:0]   n_code;
   logic                n_dar_wr;
   logic [ADDR_W-1:0]   n_dar;
   logic                n_dsisr_wr;
   logic [CODE_W-1:0]   n_dsisr;

   logic                n_fill;
   logic [ADDR_W-1:0]   n_ea_page;
   logic [ADDR_W-1:0]   n_ra_page;
   logic [2:0]          n_rights;

   sfc_real_gate #(.ADDR_W(ADDR_W), .HI_IGNORE(HI_IGNORE)) i_gate (
      .kind      (req_kind),
      .fetch_en  (xlat_fetch_en),
      .data_en   (xlat_data_en),
      .ea        (req_ea),
      .real_mode (real_mode),
      .real_addr (real_addr)
   );

   sfc_stage_chain i_chain (
      .kind        (req_kind),
      .real_mode   (real_mode),
      .seg_hit     (seg_hit),
      .seg_noexec  (seg_noexec),
      .pte_hit     (pte_hit),
      .pte_rights  (pte_rights),
      .pte_chg_set (pte_chg_set),
      .verdict     (verdict),
      .granted     (granted)
   );

   sfc_exc_encode #(.ADDR_W(ADDR_W)) i_enc (
      .verdict  (verdict),
      .kind     (req_kind),
      .ea       (req_ea),
      .exc      (n_exc),
      .exc_kind (n_kind),
      .code     (n_code),
      .dar_wr   (n_dar_wr),
      .dar      (n_dar),
      .dsisr_wr (n_dsisr_wr),
      .dsisr    (n_dsisr)
   );

   assign n_fill    = req_valid && (verdict == V_REAL || verdict == V_PTE_OK);
   assign n_ea_page = n_fill ? (req_ea & PAGE_MASK) : '0;
   assign n_ra_page = !n_fill ? '0 :
                      (verdict == V_REAL) ? (real_addr & PAGE_MASK) : (pte_real & PAGE_MASK);
   assign n_rights  = n_fill ? granted : '0;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fill_valid   <= 1'b0;
               fill_ea_page <= '0;
               fill_ra_page <= '0;
               fill_rights  <= '0;
               exc_valid    <= 1'b0;
               exc_kind     <= EXC_NONE;
               exc_code     <= '0;
               exc_dar_wr   <= 1'b0;
               exc_dar      <= '0;
               exc_dsisr_wr <= 1'b0;
               exc_dsisr    <= '0;
            end else begin
               fill_valid   <= n_fill;
               fill_ea_page <= n_ea_page;
               fill_ra_page <= n_ra_page;
               fill_rights  <= n_rights;
               exc_valid    <= req_valid && n_exc;
               exc_kind     <= req_valid ? n_kind : EXC_NONE;
               exc_code     <= req_valid ? n_code : '0;
               exc_dar_wr   <= req_valid && n_dar_wr;
               exc_dar      <= req_valid ? n_dar : '0;
               exc_dsisr_wr <= req_valid && n_dsisr_wr;
               exc_dsisr    <= req_valid ? n_dsisr : '0;
            end
         end

         // R2
         answer_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_kind != 2'd3) |=> (fill_valid || exc_valid));
         // R2
         quiet_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> (!fill_valid && !exc_valid));
      end else begin : g_comb
         assign fill_valid   = n_fill;
         assign fill_ea_page = n_ea_page;
         assign fill_ra_page = n_ra_page;
         assign fill_rights  = n_rights;
         assign exc_valid    = req_valid && n_exc;
         assign exc_kind     = req_valid ? n_kind : EXC_NONE;
         assign exc_code     = req_valid ? n_code : '0;
         assign exc_dar_wr   = req_valid && n_dar_wr;
         assign exc_dar      = req_valid ? n_dar : '0;
         assign exc_dsisr_wr = req_valid && n_dsisr_wr;
         assign exc_dsisr    = req_valid ? n_dsisr : '0;
      end
   endgenerate

   // R2
   legal_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_kind != 2'd3);
   // R2
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && exc_valid));
   // R9
   page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> ((fill_ea_page & ~PAGE_MASK) == '0 && (fill_ra_page & ~PAGE_MASK) == '0));
   // R4
   iside_no_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && (exc_kind == EXC_ISTOR || exc_kind == EXC_ISEG)) |-> (!exc_dar_wr && !exc_dsisr_wr));
   // R4
   dseg_dar_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_kind == EXC_DSEG) |-> (exc_dar_wr && !exc_dsisr_wr && exc_code == '0));

endmodule

// File: tb/test_slb_fault_classifier.sv
module test_slb_fault_classifier;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic        xlat_fetch_en = 1'b0;
   logic        xlat_data_en = 1'b0;
   logic [63:0] req_ea = '0;
   logic        seg_hit = 1'b0;
   logic        seg_noexec = 1'b0;
   logic        pte_hit = 1'b0;
   logic [2:0]  pte_rights = '0;
   logic [63:0] pte_real = '0;
   logic        pte_chg_set = 1'b0;
   logic        fill_valid;
   logic [63:0] fill_ea_page;
   logic [63:0] fill_ra_page;
   logic [2:0]  fill_rights;
   logic        exc_valid;
   logic [2:0]  exc_kind;
   logic [31:0] exc_code;
   logic        exc_dar_wr;
   logic [63:0] exc_dar;
   logic        exc_dsisr_wr;
   logic [31:0] exc_dsisr;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   typedef struct {
      string       tag;
      int          due;
      logic        fill;
      logic [63:0] eap;
      logic [63:0] rap;
      logic [2:0]  rt;
      logic        exc;
      logic [2:0]  ek;
      logic [31:0] code;
      logic        dw;
      logic [63:0] dar;
      logic        sw;
      logic [31:0] dsisr;
   } exp_t;

   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   slb_fault_classifier i_slb_fault_classifier (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .xlat_fetch_en(xlat_fetch_en), .xlat_data_en(xlat_data_en), .req_ea(req_ea),
      .seg_hit(seg_hit), .seg_noexec(seg_noexec), .pte_hit(pte_hit),
      .pte_rights(pte_rights), .pte_real(pte_real), .pte_chg_set(pte_chg_set),
      .fill_valid(fill_valid), .fill_ea_page(fill_ea_page), .fill_ra_page(fill_ra_page),
      .fill_rights(fill_rights), .exc_valid(exc_valid), .exc_kind(exc_kind),
      .exc_code(exc_code), .exc_dar_wr(exc_dar_wr), .exc_dar(exc_dar),
      .exc_dsisr_wr(exc_dsisr_wr), .exc_dsisr(exc_dsisr)
   );

   task automatic fail(string tag, string what);
      errors++;
      $display("FAIL %s: %s", tag, what);
   endtask

   // expected result from the requirements
   function automatic exp_t model(string tag, logic [1:0] k, logic fe, logic de, logic [63:0] ea,
                                  logic sh, logic nx, logic ph, logic [2:0] rt, logic [63:0] ra, logic cs);
      exp_t e;
      logic off;
      logic [2:0] need;
      logic st;
      e = '{tag: tag, due: 0, fill: 0, eap: 0, rap: 0, rt: 0, exc: 0, ek: 0, code: 0,
            dw: 0, dar: 0, sw: 0, dsisr: 0};
      off  = (k == 2'd2) ? !fe : !de;
      need = (k == 2'd0) ? 3'b001 : (k == 2'd1) ? 3'b010 : 3'b100;
      st   = (k == 2'd1);
      if (off) begin
         e.fill = 1; e.eap = ea & ~64'hFFF; e.rap = ea & 64'h0FFF_FFFF_FFFF_F000; e.rt = 3'b111;
      end else if (!sh) begin
         e.exc = 1;
         if (k == 2'd2) e.ek = 3'd3;
         else begin e.ek = 3'd4; e.dw = 1; e.dar = ea; end
      end else if (k == 2'd2 && nx) begin
         e.exc = 1; e.ek = 3'd1; e.code = 32'h1000_0000;
      end else if (!ph || (need & ~rt) != 0) begin
         e.exc = 1;
         if (k == 2'd2) begin
            e.ek = 3'd1; e.code = !ph ? 32'h4000_0000 : 32'h0800_0000;
         end else begin
            e.ek = 3'd2; e.dw = 1; e.dar = ea; e.sw = 1;
            e.dsisr = !ph ? (st ? 32'h4200_0000 : 32'h4000_0000)
                          : (st ? 32'h0A00_0000 : 32'h0800_0000);
         end
      end else begin
         e.fill = 1; e.eap = ea & ~64'hFFF; e.rap = ra & ~64'hFFF;
         e.rt = cs ? rt : (rt & 3'b101);
      end
      return e;
   endfunction

   task automatic send(string tag, logic [1:0] k, logic fe, logic de, logic [63:0] ea,
                       logic sh, logic nx, logic ph, logic [2:0] rt, logic [63:0] ra, logic cs);
      exp_t e;
      @(negedge clk);
      req_valid = 1; req_kind = k; xlat_fetch_en = fe; xlat_data_en = de; req_ea = ea;
      seg_hit = sh; seg_noexec = nx; pte_hit = ph; pte_rights = rt; pte_real = ra; pte_chg_set = cs;
      e = model(tag, k, fe, de, ea, sh, nx, ph, rt, ra, cs);
      e.due = cyc + 1;
      q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 0;
         req_ea = 64'hDEAD_BEEF_0000_0000 + 64'(i);
      end
   endtask

   // monitor: pop and compare
   always @(negedge clk) begin
      if (rst_n) begin
         if (fill_valid || exc_valid) begin
            if (q.size() == 0) begin
               checks++;
               fail("R2", $sformatf("strobe without request fill=%0b exc=%0b expected 0 0",
                                    fill_valid, exc_valid));
            end else begin
               exp_t e;
               e = q.pop_front();
               checks++;
               if (fill_valid !== e.fill || exc_valid !== e.exc ||
                   (e.fill && (fill_ea_page !== e.eap || fill_ra_page !== e.rap || fill_rights !== e.rt)) ||
                   (e.exc && (exc_kind !== e.ek || exc_code !== e.code || exc_dar_wr !== e.dw ||
                              exc_dsisr_wr !== e.sw || (e.dw && exc_dar !== e.dar) ||
                              (e.sw && exc_dsisr !== e.dsisr))))
                  fail(e.tag, $sformatf(
                     "act fill=%0b ea=%h ra=%h rt=%b exc=%0b k=%0d code=%h dw=%0b dar=%h sw=%0b dsisr=%h | exp fill=%0b ea=%h ra=%h rt=%b exc=%0b k=%0d code=%h dw=%0b dar=%h sw=%0b dsisr=%h",
                     fill_valid, fill_ea_page, fill_ra_page, fill_rights, exc_valid, exc_kind, exc_code,
                     exc_dar_wr, exc_dar, exc_dsisr_wr, exc_dsisr,
                     e.fill, e.eap, e.rap, e.rt, e.exc, e.ek, e.code, e.dw, e.dar, e.sw, e.dsisr));
            end
         end else if (q.size() != 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            fail(e.tag, "no strobe one cycle after request, expected one");
         end
      end
   end

   initial begin
      #200_000;
      checks++;
      fail("WATCHDOG", "run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] ea;
      // R1: strobes low in reset
      repeat (3) @(negedge clk);
      checks++;
      if (fill_valid !== 1'b0 || exc_valid !== 1'b0)
         fail("R1", $sformatf("in reset fill=%0b exc=%0b expected 0 0", fill_valid, exc_valid));
      rst_n = 1;
      idle(3);
      checks++;
      if (fill_valid !== 1'b0 || exc_valid !== 1'b0)
         fail("R1", $sformatf("after reset fill=%0b exc=%0b expected 0 0", fill_valid, exc_valid));

      // R3: real mode, other inputs ignored, top bits cleared
      send("R3 load real",  2'd0, 1, 0, 64'hF234_5678_9ABC_DEF0, 0, 1, 0, 3'b000, 64'h1111_0000, 0);
      send("R3 store real", 2'd1, 1, 0, 64'hA000_0000_0000_1FFF, 0, 0, 0, 3'b000, 64'h0, 0);
      send("R3 fetch real", 2'd2, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, 3'b000, 64'h0, 0);
      // R3: fetch enable does not govern data side
      send("R3 data xlat on", 2'd0, 0, 1, 64'h0000_0000_0040_0123, 0, 0, 0, 3'b111, 64'h0, 1);
      idle(2);
      // R4: segment misses
      send("R4 fetch segmiss", 2'd2, 1, 1, 64'h8000_0000_0000_2000, 0, 0, 1, 3'b111, 64'h5000, 1);
      send("R4 load segmiss",  2'd0, 1, 1, 64'h1234_0000_0000_0ABC, 0, 0, 1, 3'b111, 64'h5000, 1);
      send("R4 store segmiss", 2'd1, 1, 1, 64'h0000_0000_7777_7777, 0, 1, 0, 3'b000, 64'h5000, 1);
      // R5: no-execute
      send("R5 fetch noexec", 2'd2, 1, 1, 64'h0000_0000_0010_0004, 1, 1, 1, 3'b111, 64'h9000, 1);
      send("R5 load noexec ignored", 2'd0, 1, 1, 64'h0000_0000_0010_0008, 1, 1, 1, 3'b001, 64'h0000_0000_ABCD_E123, 1);
      // R6: entry misses
      send("R6 fetch ptemiss", 2'd2, 1, 1, 64'h0000_0000_0020_0000, 1, 0, 0, 3'b111, 64'h0, 1);
      send("R6 load ptemiss",  2'd0, 1, 1, 64'h0000_0000_0020_0010, 1, 0, 0, 3'b111, 64'h0, 1);
      send("R6 store ptemiss", 2'd1, 1, 1, 64'h0000_0000_0020_0020, 1, 1, 0, 3'b111, 64'h0, 1);
      // R7: permission
      send("R7 fetch prot", 2'd2, 1, 1, 64'h0000_0000_0030_0000, 1, 0, 1, 3'b011, 64'h0, 1);
      send("R7 load prot",  2'd0, 1, 1, 64'h0000_0000_0030_0100, 1, 0, 1, 3'b110, 64'h0, 1);
      send("R7 store prot", 2'd1, 1, 1, 64'h0000_0000_0030_0200, 1, 0, 1, 3'b101, 64'h0, 1);
      idle(1);
      // R8: overlapping faults, earliest wins
      send("R8 segmiss over noexec", 2'd2, 1, 1, 64'h40_0000, 0, 1, 0, 3'b000, 64'h0, 0);
      send("R8 noexec over ptemiss", 2'd2, 1, 1, 64'h41_0000, 1, 1, 0, 3'b000, 64'h0, 0);
      send("R8 ptemiss over prot",   2'd1, 1, 1, 64'h42_0000, 1, 0, 0, 3'b000, 64'h0, 0);
      send("R8 real over all",       2'd1, 1, 0, 64'h43_0000, 0, 1, 0, 3'b000, 64'h0, 0);
      // R9: success, write dropped unless changed set
      send("R9 store chg",    2'd1, 1, 1, 64'h0000_0000_0050_0ABC, 1, 0, 1, 3'b111, 64'hF000_0000_1234_5FFF, 1);
      send("R9 load nochg",   2'd0, 1, 1, 64'h0000_0000_0051_0001, 1, 0, 1, 3'b111, 64'h0000_0000_8888_8001, 0);
      send("R9 store nochg",  2'd1, 1, 1, 64'h0000_0000_0052_0002, 1, 0, 1, 3'b010, 64'h0000_0000_7777_7002, 0);
      send("R9 fetch ok",     2'd2, 1, 1, 64'h0000_0000_0053_0FFF, 1, 0, 1, 3'b100, 64'h0000_0000_6666_6000, 0);
      idle(2);
      // R2: random mix back to back with gaps
      for (int i = 0; i < 400; i++) begin
         ea = {$urandom(), $urandom()};
         send("R2 random", 2'($urandom_range(0, 2)), 1'($urandom()), 1'($urandom()), ea,
              1'($urandom()), 1'($urandom()), 1'($urandom()), 3'($urandom()),
              {$urandom(), $urandom()}, 1'($urandom()));
         if ((i % 7) == 0) idle(1);
      end
      idle(4);
      checks++;
      if (q.size() != 0) fail("R2", $sformatf("%0d results missing, expected 0", q.size()));
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule